// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. It takes two operand bytes (the second may already be an immediate selected upstream), a five-bit operation code and a bit selector. It returns the result byte, a write-enable for the destination register and the status byte the operation would produce. An internal status register holds the eight flags and loads the new status byte on every clock edge.

Every operation changes only the flags that belong to it. Compares change flags but raise no write-enable. The carry-chained subtract and compare operations keep the zero flag sticky, so a multi-byte equality test leaves zero set only when every byte matched. Test and clear need no codes of their own: the decoder issues AND or XOR with both operands equal to the register.

Top module: `alu8_flags`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Reset clears `flags_q` to 0x00.
- R2: ADD (code 1) returns opa+opb, and ADC (2) returns opa+opb+C. Both write the result and update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N, Z and S. LSL (14) acts as ADD with opb=opa, and ROL (15) acts as ADC with opb=opa.
- R3: SUB (3) returns opa-opb, SBC (4) returns opa-opb-C and NEG (7) returns 0-opa. Each updates C (borrow out of bit 7), H (borrow out of bit 3), V, N, Z and S, and writes the result.
- R4: For SBC and CPC (6), the new Z is 1 only when the result is zero and the old Z was 1.
- R5: CP (5) and CPC update the same flags as SUB and SBC, and `wr_en` stays 0.
- R6: AND (8), OR (9), XOR (10), INC (11) and DEC (12) update only Z, N, V and S. V is 0 for the three logic operations, is set by INC when the operand was 0x7F and by DEC when the operand was 0x80.
- R7: COM (13) returns 0xFF-opa, sets C to 1, clears V and updates N, Z and S.
- R8: LSR (16), ASR (17) and ROR (18) shift right. LSR fills bit 7 with 0, ASR keeps bit 7 and ROR loads the old C into bit 7. C takes the old bit 0, and V becomes N XOR C. H is not changed.
- R9: SWAP (19) exchanges the two nibbles of opa, and SER (20) returns 0xFF. Both write the result and leave all flags unchanged.
- R10: BST (21) copies bit `bsel` of opa into T and does not write. BLD (22) writes opa with bit `bsel` replaced by T.
- R11: BSET (23) sets and BCLR (24) clears status bit `bsel`. All other status bits are unchanged and no write occurs.
- R12: After every operation of R2, R3, R5, R6, R7 and R8, S equals N XOR V.
- R13: `flags_q` loads `flags_next` on each clock edge. NOP (0) leaves all flags unchanged and raises no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation code, values as listed in the requirements |
| opa | input | 8 | First operand, the destination register's value |
| opb | input | 8 | Second operand: a register or an immediate |
| bsel | input | 3 | Bit selector for BST, BLD, BSET and BCLR |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Destination write-enable |
| flags_next | output | 8 | Status byte after the current operation |
| flags_q | output | 8 | Registered status byte |

## Verification
The two functions that share a cycle are the status register load for one operation and the carry-consuming next operation (ADC, SBC, CPC, ROL, ROR), which reads the flag registered one edge earlier. The bench provokes this with back-to-back sweeps of the same operation, so each step uses the carry and zero left by the step before it. It also runs 16-bit add and compare chains issued on consecutive cycles. The chained results, and the final zero and carry, are compared with plain 16-bit arithmetic computed in the bench.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SUB  = 5'd3,
    OP_SBC  = 5'd4,
    OP_CP   = 5'd5,
    OP_CPC  = 5'd6,
    OP_NEG  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_COM  = 5'd13,
    OP_LSL  = 5'd14,
    OP_ROL  = 5'd15,
    OP_LSR  = 5'd16,
    OP_ASR  = 5'd17,
    OP_ROR  = 5'd18,
    OP_SWAP = 5'd19,
    OP_SER  = 5'd20,
    OP_BST  = 5'd21,
    OP_BLD  = 5'd22,
    OP_BSET = 5'd23,
    OP_BCLR = 5'd24
  } alu_op_e;

  // status bit positions (R1)
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int F_T = 6;
  localparam int F_I = 7;

  localparam int STATUS_W = 8;

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Shared adder/subtractor: one carry chain, split after the low part for H.
module alu8_addsub #(
  parameter int DW    = 8,
  parameter int LOW_W = 4
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  logic [DW-1:0] y_eff;
  logic          c_eff;
  logic [LOW_W:0] low_sum;
  logic [DW:0]    full_sum;

  always_comb begin
    y_eff    = sub ? ~y : y;
    c_eff    = sub ? ~cin : cin;
    low_sum  = {1'b0, x[LOW_W-1:0]} + {1'b0, y_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, c_eff};
    full_sum = {1'b0, x} + {1'b0, y_eff} + {{DW{1'b0}}, c_eff};
    r        = full_sum[DW-1:0];
    // a subtract reports borrow, the inverse of the chain's carry
    c_out    = full_sum[DW] ^ sub;
    h_out    = low_sum[LOW_W] ^ sub;
    v_out    = (x[DW-1] == y_eff[DW-1]) && (r[DW-1] != x[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
// Logic, unary, shift and nibble operations.
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c_out,
  output logic          v_out
);
  localparam int            HW     = DW / 2;
  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINNEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    r     = a;
    c_out = 1'b0;
    v_out = 1'b0;
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  begin r = ~a; c_out = 1'b1; end
      OP_INC:  begin r = a + ONE; v_out = (a == MAXPOS); end
      OP_DEC:  begin r = a - ONE; v_out = (a == MINNEG); end
      OP_LSR:  begin r = {1'b0, a[DW-1:1]};     c_out = a[0]; end
      OP_ASR:  begin r = {a[DW-1], a[DW-1:1]};  c_out = a[0]; end
      OP_ROR:  begin r = {cin, a[DW-1:1]};      c_out = a[0]; end
      OP_SWAP: r = {a[HW-1:0], a[DW-1:HW]};
      OP_SER:  r = {DW{1'b1}};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_bitfield.sv
`timescale 1ns/1ps
// Single-bit extract/insert on the operand and single-bit write on the status byte.
module alu8_bitfield #(
  parameter int DW = 8,
  parameter int SW = 8,
  localparam int BW = $clog2(DW),
  localparam int FW = $clog2(SW)
) (
  input  logic [DW-1:0] a,
  input  logic [BW-1:0] sel,
  input  logic          tval,
  input  logic [SW-1:0] flags,
  input  logic [FW-1:0] fsel,
  input  logic          fval,
  output logic [DW-1:0] ins,
  output logic          ext,
  output logic [SW-1:0] flags_w
);
  assign ext = a[sel];

  for (genvar i = 0; i < DW; i++) begin : g_ins
    assign ins[i] = (sel == BW'(i)) ? tval : a[i];
  end

  for (genvar j = 0; j < SW; j++) begin : g_flag
    assign flags_w[j] = (fsel == FW'(j)) ? fval : flags[j];
  end
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LOW_W = 4,
  localparam int BW   = $clog2(DW),
  localparam int SW   = STATUS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [SW-1:0] flags_next,
  output logic [SW-1:0] flags_q
);
  localparam int FW = $clog2(SW);

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // adder operand routing
  logic [DW-1:0] as_x, as_y, as_r;
  logic          as_cin, as_sub, as_c, as_h, as_v;

  always_comb begin
    as_x   = opa;
    as_y   = opb;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (opc)
      OP_ADC:         as_cin = flags_q[F_C];
      OP_LSL:         as_y   = opa;
      OP_ROL:         begin as_y = opa; as_cin = flags_q[F_C]; end
      OP_SUB, OP_CP:  as_sub = 1'b1;
      OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = flags_q[F_C]; end
      OP_NEG:         begin as_x = '0; as_y = opa; as_sub = 1'b1; end
      default:        ;
    endcase
  end

  alu8_addsub #(.DW(DW), .LOW_W(LOW_W)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .r(as_r), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  logic [DW-1:0] lg_r;
  logic          lg_c, lg_v;

  alu8_logic #(.DW(DW)) u_logic (
    .op(opc), .a(opa), .b(opb), .cin(flags_q[F_C]),
    .r(lg_r), .c_out(lg_c), .v_out(lg_v)
  );

  logic [DW-1:0] bf_ins;
  logic          bf_ext;
  logic [SW-1:0] bf_flags;

  alu8_bitfield #(.DW(DW), .SW(SW)) u_bitfield (
    .a(opa), .sel(bsel), .tval(flags_q[F_T]),
    .flags(flags_q), .fsel(FW'(bsel)), .fval(opc == OP_BSET),
    .ins(bf_ins), .ext(bf_ext), .flags_w(bf_flags)
  );

  // flag composition: each class touches only its own subset
  logic [SW-1:0] nf;
  logic [DW-1:0] res;
  logic          we;
  logic          res_zero;

  always_comb begin
    nf  = flags_q;
    res = opa;
    we  = 1'b0;
    case (opc)
      OP_ADD, OP_ADC, OP_LSL, OP_ROL,
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res    = as_r;
        we     = !(opc == OP_CP || opc == OP_CPC);
        nf[F_C] = as_c;
        nf[F_H] = as_h;
        nf[F_V] = as_v;
        nf[F_N] = as_r[DW-1];
        if (opc == OP_SBC || opc == OP_CPC)
          nf[F_Z] = (as_r == '0) && flags_q[F_Z];
        else
          nf[F_Z] = (as_r == '0);
        nf[F_S] = as_r[DW-1] ^ as_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_COM: begin
        res     = lg_r;
        we      = 1'b1;
        if (opc == OP_COM) nf[F_C] = lg_c;
        nf[F_V] = lg_v;
        nf[F_N] = lg_r[DW-1];
        nf[F_Z] = (lg_r == '0);
        nf[F_S] = lg_r[DW-1] ^ lg_v;
      end
      OP_LSR, OP_ASR, OP_ROR: begin
        res     = lg_r;
        we      = 1'b1;
        nf[F_C] = lg_c;
        nf[F_N] = lg_r[DW-1];
        nf[F_Z] = (lg_r == '0);
        nf[F_V] = lg_r[DW-1] ^ lg_c;
        // S = N ^ V = N ^ N ^ C = C
        nf[F_S] = lg_c;
      end
      OP_SWAP, OP_SER: begin
        res = lg_r;
        we  = 1'b1;
      end
      OP_BST:            nf[F_T] = bf_ext;
      OP_BLD:            begin res = bf_ins; we = 1'b1; end
      OP_BSET, OP_BCLR:  nf = bf_flags;
      default:           ;
    endcase
  end

  assign res_zero   = (res == '0);
  assign result     = res;
  assign wr_en      = we;
  assign flags_next = nf;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= nf;
  end
endmodule

// File: rtl/alu8_flags_chk.sv
`timescale 1ns/1ps
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    op,
  input logic [BW-1:0] bsel,
  input logic          wr_en,
  input logic [7:0]    flags_next,
  input logic [7:0]    flags_q
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> flags_q == 8'h00);

  p_load_next_r13: assert property (@(posedge clk) disable iff (rst)
    !rst |=> flags_q == $past(flags_next));

  p_nop_hold_r13: assert property (@(posedge clk) disable iff (rst)
    op == OP_NOP |-> (flags_next == flags_q) && !wr_en);

  p_sticky_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (op inside {OP_SBC, OP_CPC}) && !flags_q[F_Z] |-> !flags_next[F_Z]);

  p_compare_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    op inside {OP_CP, OP_CPC} |-> !wr_en);

  p_logic_keep_ch_r6: assert property (@(posedge clk) disable iff (rst)
    op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC} |->
      (flags_next[F_C] == flags_q[F_C]) && (flags_next[F_H] == flags_q[F_H]) &&
      (flags_next[F_T] == flags_q[F_T]) && (flags_next[F_I] == flags_q[F_I]));

  p_com_flags_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_COM |-> flags_next[F_C] && !flags_next[F_V]);

  p_shift_keep_h_r8: assert property (@(posedge clk) disable iff (rst)
    op inside {OP_LSR, OP_ASR, OP_ROR} |-> flags_next[F_H] == flags_q[F_H]);

  p_no_flag_change_r9: assert property (@(posedge clk) disable iff (rst)
    op inside {OP_SWAP, OP_SER} |-> (flags_next == flags_q) && wr_en);

  p_bst_only_t_r10: assert property (@(posedge clk) disable iff (rst)
    op == OP_BST |-> ((flags_next ^ flags_q) & 8'hBF) == 8'h00 && !wr_en);

  p_single_bit_r11: assert property (@(posedge clk) disable iff (rst)
    op inside {OP_BSET, OP_BCLR} |->
      ($countones(flags_next ^ flags_q) <= 1) &&
      (flags_next[bsel] == (op == OP_BSET)) && !wr_en);

  p_sign_rule_r12: assert property (@(posedge clk) disable iff (rst)
    (op inside {[OP_ADD:OP_ROR]}) |-> flags_next[F_S] == (flags_next[F_N] ^ flags_next[F_V]));
endmodule

bind alu8_flags alu8_flags_chk #(.BW(BW)) u_alu8_flags_chk (
  .clk(clk), .rst(rst), .op(op), .bsel(bsel), .wr_en(wr_en),
  .flags_next(flags_next), .flags_q(flags_q)
);

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] op;
  logic [7:0] a, b;
  logic [2:0] bs;
  logic [7:0] result, flags_next, flags_q;
  logic       wr_en;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [7:0] exp_q;

  always #2.5 clk = ~clk;

  alu8_flags uut (
    .clk(clk), .rst(rst), .op(op), .opa(a), .opb(b), .bsel(bs),
    .result(result), .wr_en(wr_en), .flags_next(flags_next), .flags_q(flags_q)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Expected behaviour from the requirements, computed with integer arithmetic.
  function automatic void model(input alu_op_e o, input logic [7:0] x, input logic [7:0] y,
                                input logic [2:0] s, input logic [7:0] f,
                                output logic [7:0] r, output logic w, output logic [7:0] nf);
    int xx, yy, ci, u, sv;
    logic vv, cc;
    nf = f; r = x; w = 1'b0;
    case (o)
      OP_ADD, OP_ADC, OP_LSL, OP_ROL: begin            // R2
        xx = int'(x);
        yy = (o == OP_LSL || o == OP_ROL) ? int'(x) : int'(y);
        ci = (o == OP_ADC || o == OP_ROL) ? int'(f[0]) : 0;
        u  = xx + yy + ci;
        r  = 8'(u); w = 1'b1;
        nf[0] = (u > 255);
        nf[5] = ((xx % 16) + (yy % 16) + ci) > 15;
        sv = sgn(xx) + sgn(yy) + ci;
        vv = (sv > 127) || (sv < -128);
        nf[3] = vv; nf[2] = r[7]; nf[1] = (r == 8'h00); nf[4] = r[7] ^ vv;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin     // R3, R4, R5
        xx = (o == OP_NEG) ? 0 : int'(x);
        yy = (o == OP_NEG) ? int'(x) : int'(y);
        ci = (o == OP_SBC || o == OP_CPC) ? int'(f[0]) : 0;
        u  = xx - yy - ci;
        r  = 8'(u);
        w  = !(o == OP_CP || o == OP_CPC);
        nf[0] = (u < 0);
        nf[5] = ((xx % 16) - (yy % 16) - ci) < 0;
        sv = sgn(xx) - sgn(yy) - ci;
        vv = (sv > 127) || (sv < -128);
        nf[3] = vv; nf[2] = r[7];
        nf[1] = (r == 8'h00) && ((o == OP_SBC || o == OP_CPC) ? f[1] : 1'b1);
        nf[4] = r[7] ^ vv;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_COM: begin  // R6, R7
        vv = 1'b0;
        case (o)
          OP_AND: r = x & y;
          OP_OR:  r = x | y;
          OP_XOR: r = x ^ y;
          OP_INC: begin r = 8'(int'(x) + 1); vv = (x == 8'd127); end
          OP_DEC: begin r = 8'(int'(x) - 1); vv = (x == 8'd128); end
          default: begin r = 8'(255 - int'(x)); nf[0] = 1'b1; end
        endcase
        w = 1'b1;
        nf[3] = vv; nf[2] = r[7]; nf[1] = (r == 8'h00); nf[4] = r[7] ^ vv;
      end
      OP_LSR, OP_ASR, OP_ROR: begin                    // R8
        xx = int'(x);
        cc = x[0];
        u  = xx / 2;
        if (o == OP_ASR && xx >= 128) u = u + 128;
        if (o == OP_ROR && f[0])      u = u + 128;
        r = 8'(u); w = 1'b1;
        nf[0] = cc; nf[2] = r[7]; nf[1] = (r == 8'h00);
        nf[3] = r[7] ^ cc; nf[4] = r[7] ^ (r[7] ^ cc);
      end
      OP_SWAP: begin r = 8'((int'(x) % 16) * 16 + int'(x) / 16); w = 1'b1; end  // R9
      OP_SER:  begin r = 8'hFF; w = 1'b1; end                                   // R9
      OP_BST:  nf[6] = x[s];                                                    // R10
      OP_BLD:  begin r = x; r[s] = f[6]; w = 1'b1; end                          // R10
      OP_BSET: nf[s] = 1'b1;                                                    // R11
      OP_BCLR: nf[s] = 1'b0;                                                    // R11
      default: ;                                                                // R13
    endcase
  endfunction

  function automatic string req_of(input alu_op_e o);
    case (o)
      OP_ADD, OP_ADC, OP_LSL, OP_ROL: return "R2,R12,R13";
      OP_SUB, OP_SBC, OP_NEG:         return "R3,R4,R12,R13";
      OP_CP, OP_CPC:                  return "R5,R4,R12,R13";
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: return "R6,R12,R13";
      OP_COM:                         return "R7,R12,R13";
      OP_LSR, OP_ASR, OP_ROR:         return "R8,R12,R13";
      OP_SWAP, OP_SER:                return "R9,R13";
      OP_BST, OP_BLD:                 return "R10,R13";
      OP_BSET, OP_BCLR:               return "R11,R13";
      default:                        return "R13";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, want);
    end
  endtask

  // One operation: drive at the falling edge, compare just after, advance the model.
  task automatic step(input alu_op_e o, input logic [7:0] x, input logic [7:0] y,
                      input logic [2:0] s);
    logic [7:0] er, en;
    logic       ew;
    @(negedge clk);
    op = o; a = x; b = y; bs = s;
    #1;
    model(o, x, y, s, exp_q, er, ew, en);
    checks++;
    if (flags_q !== exp_q || wr_en !== ew || flags_next !== en || (ew && result !== er)) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sel=%0d: got res=%h wr=%b next=%h q=%h expected res=%h wr=%b next=%h q=%h",
               req_of(o), o, x, y, s, result, wr_en, flags_next, flags_q, er, ew, en, exp_q);
    end
    exp_q = en;
  endtask

  // Park with NOP so the registered flags can be read without re-executing.
  task automatic park;
    @(negedge clk);
    op = OP_NOP;
    #1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] xs [6];
    logic [15:0] ys [6];
    logic [15:0] sum16;
    logic [7:0]  lo_res;
    rst = 1'b1; op = OP_NOP; a = '0; b = '0; bs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(flags_q == 8'h00, "R1", "flags after reset", 32'(flags_q), 32'h0);
    rst = 1'b0;
    exp_q = 8'h00;

    // R1: fill the flags, then reset again mid-run
    for (int i = 0; i < 8; i++) step(OP_BSET, 8'h00, 8'h00, 3'(i));
    @(negedge clk); rst = 1'b1; op = OP_NOP;
    @(negedge clk); #1;
    check(flags_q == 8'h00, "R1", "flags after second reset", 32'(flags_q), 32'h0);
    rst = 1'b0; exp_q = 8'h00;

    // sweep every code; consecutive steps chain through the registered flags
    for (int oi = 0; oi <= 24; oi++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int bi = 0; bi < 16; bi++) begin
          step(alu_op_e'(oi), 8'(ai), 8'((bi * 17) ^ (ai >> 3)), 3'((ai + bi) % 8));
        end
      end
    end

    // back-to-back 16-bit chains (R2 add, R4 compare)
    xs = '{16'h1234, 16'h1234, 16'h1200, 16'hFFFF, 16'h8000, 16'h00FF};
    ys = '{16'h1234, 16'h1334, 16'h1234, 16'h0001, 16'h7FFF, 16'h0100};
    for (int k = 0; k < 6; k++) begin
      sum16 = xs[k] + ys[k];
      step(OP_ADD, xs[k][7:0], ys[k][7:0], 3'd0);
      lo_res = result;
      step(OP_ADC, xs[k][15:8], ys[k][15:8], 3'd0);
      check({result, lo_res} == sum16, "R2", "16-bit chained sum", 32'({result, lo_res}), 32'(sum16));
      step(OP_CP,  xs[k][7:0],  ys[k][7:0],  3'd0);
      step(OP_CPC, xs[k][15:8], ys[k][15:8], 3'd0);
      park;
      check(flags_q[F_Z] == (xs[k] == ys[k]), "R4", "16-bit compare zero",
            32'(flags_q[F_Z]), 32'(xs[k] == ys[k]));
      check(flags_q[F_C] == (xs[k] < ys[k]), "R5", "16-bit compare borrow",
            32'(flags_q[F_C]), 32'(xs[k] < ys[k]));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule